// File: doc/BRIEF.md
# Opcode-Length Command Parser with Interface Lock

This block sits behind a host byte interface of a display controller. Every incoming byte carries a valid strobe and a flag that says whether it is an opcode or a parameter. The parser looks up how many parameter bytes each opcode needs, from none up to sixty-four. It collects those bytes and, on the last one, reports the finished command for one cycle together with its opcode and its first two parameter bytes.

Two long commands load tables instead of passing values through: a 64-entry drive-current table and a 15-entry pulse-width table. Both are gathered in a staging buffer and are written only when the command is complete. The block also holds the active line count, which keeps its last valid value. A lock command can shut the interface: while it is locked, only the exact unlock sequence is accepted.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset, `done` is 0, `locked` is 0, `mux_lines` is 127 and every entry of both tables is 0.
- R2: `in_is_cmd`=1 marks an opcode byte and 0 marks a parameter byte. Opcodes 0x15 and 0x75 take two parameters. Opcodes 0x81, 0xA0, 0xA1, 0xA2, 0xA8, 0xB1, 0xB2, 0xB3 and 0xFD take one. In the cycle after the clock edge that accepts the last parameter, `done` is 1 for one cycle and `op` shows the opcode. `arg[7:0]` holds the first parameter, and `arg[15:8]` holds the second parameter, or 0 when there is only one.
- R3: Opcode 0x92 takes 64 parameters. Entry i of `icon_cur` (bits i*7+6..i*7) takes the low 7 bits of parameter i. The table does not change until the 64th byte arrives, and then all entries change on the same edge. `arg` reports the first two parameters.
- R4: Opcodes 0xA4 to 0xA7, 0xAE, 0xAF, 0xB7 and 0xE3 take no parameters. Each raises `done` in the cycle after the opcode edge, with `arg`=0. Such opcodes sent back to back give one pulse each.
- R5: Opcode 0xB8 takes 15 parameters. Entry k of `gray_pw` (bits k*6+5..k*6, for gray level k+1) takes the low 6 bits of parameter k, and all entries are written when the command completes.
- R6: A completed 0xFD with parameter 0x13 sets `locked`, and one with 0x12 clears it. Any other value leaves `locked` unchanged. An accepted 0xFD always pulses `done`.
- R7: While `locked`=1, every opcode other than 0xFD is dropped, and so is 0xFD followed by a value other than 0x12. A dropped command gives no `done` and changes no state.
- R8: A completed 0xA8 loads `mux_lines` with parameter bits [6:0] only when that value is 15 or more. A smaller value still pulses `done` but leaves `mux_lines` unchanged.
- R9: An opcode not listed above gives no `done`, and the parameter bytes after it are ignored. A parameter byte that arrives when no command is pending is also ignored.
- R10: An opcode byte that arrives before a pending command has all its parameters abandons that command, which gives no `done`. The new byte is then parsed as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte strobe |
| in_is_cmd | input | 1 | 1 = opcode byte, 0 = parameter byte |
| in_byte | input | 8 | Byte value |
| done | output | 1 | One-cycle pulse for a completed command |
| op | output | 8 | Opcode of the last completed command |
| arg | output | 16 | First (low) and second (high) parameter of the last completed command |
| locked | output | 1 | Interface lock state |
| mux_lines | output | 7 | Active line count minus one |
| icon_cur | output | ICONS*ICON_W | Drive-current table, entry i at bits i*ICON_W |
| gray_pw | output | LEVELS*GRAY_W | Pulse-width table, entry k at bits k*GRAY_W |

## Verification
The parser is driven with commands of each length: none, one, two, fifteen and sixty-four parameters. This shows whether the length lookup and the completion edge are right for each class, and back-to-back zero-length opcodes show that pulses are not merged. Irregular streams follow: stray parameter bytes, unknown opcodes, and an opcode cut short by a new opcode. These separate the ignore path from the abandon path. A lock and unlock sequence with filtered commands in between, plus line counts just below, at and above the floor, test the gating and the range check.

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder #(
  parameter int ICONS  = 64,
  parameter int ICON_W = 7,
  parameter int LEVELS = 15,
  parameter int GRAY_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_is_cmd,
  input  logic [7:0]                 in_byte,
  output logic                       done,
  output logic [7:0]                 op,
  output logic [15:0]                arg,
  output logic                       locked,
  output logic [6:0]                 mux_lines,
  output logic [ICONS*ICON_W-1:0]    icon_cur,
  output logic [LEVELS*GRAY_W-1:0]   gray_pw
);
  localparam int CW = $clog2(ICONS + 1);
  localparam int IW = $clog2(ICONS);

  logic          busy;
  logic [7:0]    op_q;
  logic [CW-1:0] need, idx;
  logic [15:0]   arg_q;
  logic [ICON_W-1:0] stage  [ICONS];
  logic [ICON_W-1:0] icon_q [ICONS];
  logic [GRAY_W-1:0] gray_q [LEVELS];

  function automatic logic [CW:0] plen(input logic [7:0] c);
    case (c)
      8'h15, 8'h75:                              plen = {1'b1, CW'(2)};
      8'h81, 8'hA0, 8'hA1, 8'hA2, 8'hA8,
      8'hB1, 8'hB2, 8'hB3, 8'hFD:                plen = {1'b1, CW'(1)};
      8'h92:                                     plen = {1'b1, CW'(ICONS)};
      8'hB8:                                     plen = {1'b1, CW'(LEVELS)};
      8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hB7, 8'hE3:                plen = {1'b1, CW'(0)};
      default:                                   plen = '0;
    endcase
  endfunction

  wire [CW:0]    pl     = plen(in_byte);
  wire           known  = pl[CW];
  wire [CW-1:0]  cnt    = pl[CW-1:0];
  wire           cmd_in = in_valid & in_is_cmd;
  wire           dat_in = in_valid & ~in_is_cmd & busy;
  wire           allow  = ~locked | (in_byte == 8'hFD);
  wire           last   = dat_in & ((idx + CW'(1)) == need);
  wire           fire   = last & (~locked | (in_byte == 8'h12));
  wire           fire0  = cmd_in & known & (cnt == '0) & ~locked;
  wire [15:0]    arg_n  = (idx == '0)     ? {8'h00, in_byte} :
                          (idx == CW'(1)) ? {in_byte, arg_q[7:0]} : arg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      op_q      <= '0;
      need      <= '0;
      idx       <= '0;
      arg_q     <= '0;
      done      <= 1'b0;
      op        <= '0;
      arg       <= '0;
      locked    <= 1'b0;
      mux_lines <= 7'd127;
    end else begin
      done <= fire | fire0;
      if (cmd_in) begin
        busy <= known & allow & (cnt != '0);
        op_q <= in_byte;
        need <= cnt;
        idx  <= '0;
      end else if (dat_in) begin
        idx   <= idx + CW'(1);
        arg_q <= arg_n;
        if (last) busy <= 1'b0;
      end
      if (fire0) begin
        op  <= in_byte;
        arg <= '0;
      end
      if (fire) begin
        op  <= op_q;
        arg <= arg_n;
        if (op_q == 8'hFD) begin
          if (in_byte == 8'h13)      locked <= 1'b1;
          else if (in_byte == 8'h12) locked <= 1'b0;
        end
        if (op_q == 8'hA8 && in_byte[6:0] >= 7'd15) mux_lines <= in_byte[6:0];
      end
    end
  end

  always_ff @(posedge clk)
    if (dat_in) stage[idx[IW-1:0]] <= in_byte[ICON_W-1:0];

  for (genvar i = 0; i < ICONS; i++) begin : g_icon
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) icon_q[i] <= '0;
      else if (fire && op_q == 8'h92)
        icon_q[i] <= (idx == CW'(i)) ? in_byte[ICON_W-1:0] : stage[i];
    assign icon_cur[i*ICON_W +: ICON_W] = icon_q[i];
  end

  for (genvar k = 0; k < LEVELS; k++) begin : g_gray
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) gray_q[k] <= '0;
      else if (fire && op_q == 8'hB8)
        gray_q[k] <= (idx == CW'(k)) ? in_byte[GRAY_W-1:0] : stage[k][GRAY_W-1:0];
    assign gray_pw[k*GRAY_W +: GRAY_W] = gray_q[k];
  end
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk #(
  parameter int ICONS  = 64,
  parameter int ICON_W = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    done,
  input logic [7:0]              op,
  input logic [15:0]             arg,
  input logic                    locked,
  input logic [6:0]              mux_lines,
  input logic [ICONS*ICON_W-1:0] icon_cur
);
  AST_DONE_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid)); // R2
  AST_ICON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(icon_cur)); // R3
  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (done && op == 8'hFD && arg[7:0] == 8'h13)); // R6
  AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (done && op == 8'hFD && arg[7:0] == 8'h12)); // R6
  AST_LOCKED_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && locked) |-> op == 8'hFD); // R7
  AST_MUX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    mux_lines >= 7'd15); // R8
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk #(.ICONS(ICONS), .ICON_W(ICON_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .done(done), .op(op), .arg(arg),
  .locked(locked), .mux_lines(mux_lines), .icon_cur(icon_cur)
);

// File: tb/cmd_stream_decoder_bench.sv
`timescale 1ns/1ps
module cmd_stream_decoder_bench;
  localparam int ICONS = 64, ICON_W = 7, LEVELS = 15, GRAY_W = 6;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_is_cmd = 1'b0;
  logic [7:0] in_byte = '0;
  logic done, locked;
  logic [7:0] op;
  logic [15:0] arg;
  logic [6:0] mux_lines;
  logic [ICONS*ICON_W-1:0] icon_cur;
  logic [LEVELS*GRAY_W-1:0] gray_pw;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [23:0] sb[$];

  always #2.5 clk = ~clk;

  cmd_stream_decoder #(.ICONS(ICONS), .ICON_W(ICON_W), .LEVELS(LEVELS), .GRAY_W(GRAY_W)) u_cmd_stream_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_cmd(in_is_cmd), .in_byte(in_byte),
    .done(done), .op(op), .arg(arg), .locked(locked), .mux_lines(mux_lines),
    .icon_cur(icon_cur), .gray_pw(gray_pw));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit c, input logic [7:0] b);
    in_valid = 1'b1; in_is_cmd = c; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_cmd(input logic [7:0] o, input logic [15:0] a);
    sb.push_back({o, a});
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R7 R9 R10 unexpected done actual=%0h expected=none", {op, arg});
      end else begin
        logic [23:0] e;
        e = sb.pop_front();
        if ({op, arg} !== e) begin
          errors++;
          $display("FAIL R2 R4 command actual=%0h expected=%0h", {op, arg}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    gap(3);
    rst_n = 1'b1;
    gap(1);
    chk("R1 done", done, 0);
    chk("R1 locked", locked, 0);
    chk("R1 mux", mux_lines, 127);
    chk("R1 icon", |icon_cur, 0);
    chk("R1 gray", |gray_pw, 0);

    // R2 two and one parameter commands
    expect_cmd(8'h15, 16'h3A05); put(1, 8'h15); put(0, 8'h05); put(0, 8'h3A);
    expect_cmd(8'h81, 16'h00C8); put(1, 8'h81); put(0, 8'hC8);
    gap(2);
    chk("R2 op held", op, 8'h81);

    // R4 zero parameter, back to back
    expect_cmd(8'hA4, 16'h0000); expect_cmd(8'hAF, 16'h0000); expect_cmd(8'hE3, 16'h0000);
    put(1, 8'hA4); put(1, 8'hAF); put(1, 8'hE3);
    gap(2);

    // R9 unknown opcode and stray data
    put(1, 8'h20); put(0, 8'h55); put(0, 8'h66); put(0, 8'h77);
    gap(2);
    chk("R9 op unchanged", op, 8'hE3);

    // R10 abandon pending command
    expect_cmd(8'hA7, 16'h0000);
    put(1, 8'h15); put(0, 8'h01); put(1, 8'hA7); put(0, 8'h09);
    gap(2);
    chk("R10 op", op, 8'hA7);

    // R3 64-entry table
    expect_cmd(8'h92, 16'h0401);
    put(1, 8'h92);
    for (int i = 0; i < ICONS - 1; i++) put(0, 8'(i * 3 + 1));
    chk("R3 table held before last", |icon_cur, 0);
    put(0, 8'(63 * 3 + 1));
    for (int i = 0; i < ICONS; i++)
      chk("R3 icon entry", icon_cur[i*ICON_W +: ICON_W], 32'((i * 3 + 1) & 8'h7F));
    gap(2);

    // R5 15-entry table, upper bits discarded
    expect_cmd(8'hB8, 16'hC6C2);
    put(1, 8'hB8);
    for (int k = 0; k < LEVELS; k++) put(0, 8'hC0 | 8'(k * 4 + 2));
    for (int k = 0; k < LEVELS; k++)
      chk("R5 gray entry", gray_pw[k*GRAY_W +: GRAY_W], 32'((k * 4 + 2) & 8'h3F));
    gap(2);

    // R8 line count range
    expect_cmd(8'hA8, 16'h001F); put(1, 8'hA8); put(0, 8'h1F);
    chk("R8 mux 31", mux_lines, 31);
    expect_cmd(8'hA8, 16'h0005); put(1, 8'hA8); put(0, 8'h05);
    chk("R8 mux below floor", mux_lines, 31);
    expect_cmd(8'hA8, 16'h008F); put(1, 8'hA8); put(0, 8'h8F);
    chk("R8 mux at floor", mux_lines, 15);
    gap(2);

    // R6 R7 lock sequence
    expect_cmd(8'hFD, 16'h0013); put(1, 8'hFD); put(0, 8'h13);
    chk("R6 lock set", locked, 1);
    put(1, 8'h81); put(0, 8'h44); put(1, 8'hA4);
    put(1, 8'hA8); put(0, 8'h40);
    put(1, 8'h92); put(0, 8'h7F); put(0, 8'h7F);
    put(1, 8'hFD); put(0, 8'h11);
    gap(2);
    chk("R7 still locked", locked, 1);
    chk("R7 mux kept", mux_lines, 15);
    chk("R7 op kept", op, 8'hFD);
    chk("R7 icon kept", icon_cur[ICON_W-1:0], 1);
    expect_cmd(8'hFD, 16'h0012); put(1, 8'hFD); put(0, 8'h12);
    chk("R6 unlock", locked, 0);
    expect_cmd(8'hFD, 16'h0044); put(1, 8'hFD); put(0, 8'h44);
    chk("R6 other value", locked, 0);
    expect_cmd(8'hA5, 16'h0000); put(1, 8'hA5);
    gap(3);

    chk("R2 scoreboard drained", sb.size(), 0);
    summary();
    $finish;
  end
endmodule